// File: doc/BRIEF.md
# Dual-Form Seedable 16-bit LFSR Generator

This block is a 16-bit pseudo-random sequence generator built as a linear-feedback shift register. A static select input chooses the feedback form. In external-XOR (Fibonacci) form, the parity of the tapped bits enters at the top of the register. In internal-XOR (Galois) form, the bit that leaves the register is folded into the tapped positions. Both forms use the same maximal-length characteristic polynomial x^16 + x^14 + x^13 + x^11 + 1, so any non-zero state cycles through all 65535 non-zero values before it repeats.

Software or a controlling block writes a seed through the load port. Load takes priority over the step enable, and a seed stays in the register for as long as load remains high. When load is low and the step enable is high, the register advances by one step per clock. Two outputs are available: the full parallel state, for random words, and the serial bit shifted out on each step, for bit-stream uses.

Top module: `lfsr_dual_form`

## Requirements
- R1: On the first cycle after a synchronous active-high reset, `state_out` is 16'hACE1 and `bit_out` is 0.
- R2: When `load` is high at a clock edge, `state_out` equals `seed` from that edge onward.
- R3: While `load` stays high, `state_out` stays constant and equal to the seed, even with `step_en` high.
- R4: `load` takes priority over `step_en`. A cycle with both high loads the seed and does not step.
- R5: With `load` and `step_en` both low, `state_out` and `bit_out` keep their values.
- R6: In Fibonacci form (`sel_galois`=0), a step shifts the state right by one. The new bit 15 is old bit0 ^ bit2 ^ bit3 ^ bit5.
- R7: In Galois form (`sel_galois`=1), a step shifts the state right by one. If old bit 0 was 1, the result is XORed with 16'hB400.
- R8: On every step, `bit_out` becomes bit 0 of the state before the step. Loads do not change `bit_out`.
- R9: An all-zero seed locks the register at zero for as long as it keeps stepping (checked for at least 17 steps).
- R10: A non-zero seed returns to itself after exactly 65535 steps in either form, and never passes through zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_galois | input | 1 | Feedback form: 0 = Fibonacci, 1 = Galois |
| load | input | 1 | Seed load, takes priority over stepping |
| seed | input | 16 | Seed value written on load |
| step_en | input | 1 | Advance the register one step |
| state_out | output | 16 | Registered register state |
| bit_out | output | 1 | Registered bit shifted out on the last step |

## Verification
The hardest condition to reach from the ports is the full-period return. A seed comes back only after 65535 consecutive steps, and a short or non-maximal cycle would only show up as an early repeat. The stimulus loads seed 16'h0001 in each form and then holds `step_en` high for a full period. On every step it compares the state and the serial bit against a reference recurrence. It counts the steps until the seed reappears and expects no earlier repeat and no zero state along the way. The all-zero lock is reached directly by loading zero and stepping well past 17 cycles.

// File: rtl/lfsr_pkg.sv
`timescale 1ns/1ps
package lfsr_pkg;
  localparam int          LFSR_W_DEF    = 16;
  // Galois-form mask for x^16 + x^14 + x^13 + x^11 + 1 (right-shifting register)
  localparam logic [15:0] LFSR_POLY_DEF = 16'hB400;
  localparam logic [15:0] LFSR_INIT_DEF = 16'hACE1;

  typedef enum logic {
    FORM_FIB = 1'b0,
    FORM_GAL = 1'b1
  } lfsr_form_e;
endpackage

// File: rtl/lfsr_fib_next.sv
`timescale 1ns/1ps
// External-XOR next-state: parity of the tapped bits enters at the MSB.
module lfsr_fib_next #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   POLY = 16'hB400
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic [W-1:0] tap_mask;

  // Fibonacci tap positions are the Galois mask mirrored end for end
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_mask
      assign tap_mask[gi] = POLY[W-1-gi];
    end
  endgenerate

  logic feedback;
  assign feedback = ^(cur & tap_mask);
  assign nxt      = {feedback, cur[W-1:1]};
endmodule

// File: rtl/lfsr_gal_next.sv
`timescale 1ns/1ps
// Internal-XOR next-state: the bit leaving at the LSB is folded into the taps.
module lfsr_gal_next #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   POLY = 16'hB400
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic out_bit;
  assign out_bit = cur[0];

  genvar gi;
  generate
    for (gi = 0; gi < W-1; gi++) begin : g_stage
      assign nxt[gi] = cur[gi+1] ^ (POLY[gi] & out_bit);
    end
  endgenerate
  assign nxt[W-1] = POLY[W-1] & out_bit;
endmodule

// File: rtl/lfsr_state_reg.sv
`timescale 1ns/1ps
// State and serial-bit registers; load outranks the step enable.
module lfsr_state_reg #(
  parameter int           W          = 16,
  parameter logic [W-1:0] RESET_SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         advance,
  input  logic [W-1:0] next_state,
  input  logic         shift_bit,
  output logic [W-1:0] state_q,
  output logic         bit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RESET_SEED;
      bit_q   <= 1'b0;
    end else if (load) begin
      state_q <= seed;
    end else if (advance) begin
      state_q <= next_state;
      bit_q   <= shift_bit;
    end
  end
endmodule

// File: rtl/lfsr_dual_form.sv
`timescale 1ns/1ps
module lfsr_dual_form
  import lfsr_pkg::*;
#(
  parameter int           W          = LFSR_W_DEF,
  parameter logic [W-1:0] POLY       = LFSR_POLY_DEF,
  parameter logic [W-1:0] RESET_SEED = LFSR_INIT_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_galois,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step_en,
  output logic [W-1:0] state_out,
  output logic         bit_out
);
  lfsr_form_e   form;
  logic [W-1:0] cur_q;
  logic [W-1:0] fib_nxt;
  logic [W-1:0] gal_nxt;
  logic [W-1:0] sel_nxt;

  assign form = lfsr_form_e'(sel_galois);

  lfsr_fib_next #(.W(W), .POLY(POLY)) u_fib (
    .cur (cur_q),
    .nxt (fib_nxt)
  );

  lfsr_gal_next #(.W(W), .POLY(POLY)) u_gal (
    .cur (cur_q),
    .nxt (gal_nxt)
  );

  always_comb begin
    case (form)
      FORM_GAL: sel_nxt = gal_nxt;
      default:  sel_nxt = fib_nxt;
    endcase
  end

  lfsr_state_reg #(.W(W), .RESET_SEED(RESET_SEED)) u_reg (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .seed       (seed),
    .advance    (step_en),
    .next_state (sel_nxt),
    .shift_bit  (cur_q[0]),
    .state_q    (cur_q),
    .bit_q      (bit_out)
  );

  assign state_out = cur_q;
endmodule

// File: rtl/lfsr_dual_form_chk.sv
`timescale 1ns/1ps
module lfsr_dual_form_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         sel_galois,
  input logic         load,
  input logic [W-1:0] seed,
  input logic         step_en,
  input logic [W-1:0] state_out,
  input logic         bit_out
);
  // R2: a loaded seed is visible one clock later
  p_seed_visible_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> state_out == $past(seed));

  // R3: a held load keeps the state at the seed
  p_load_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (load && $past(load) && $stable(seed)) |=> $stable(state_out));

  // R5: idle cycles change nothing
  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && !step_en) |=> ($stable(state_out) && $stable(bit_out)));

  // R6: external-XOR step is a right shift
  p_fib_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load && !sel_galois) |=> state_out[W-2:0] == $past(state_out[W-1:1]));

  // R7: internal-XOR step carries the leaving bit into the MSB
  p_gal_msb_r7: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load && sel_galois) |=> state_out[W-1] == $past(state_out[0]));

  // R8: serial bit is the LSB before the step
  p_serial_r8: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load) |=> bit_out == $past(state_out[0]));

  // R9: zero state stays zero without a load
  p_zero_lock_r9: assert property (@(posedge clk) disable iff (rst)
    (state_out == '0 && !load) |=> state_out == '0);

  // R10: a non-zero state never steps into zero
  p_no_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (state_out != '0 && !load) |=> state_out != '0);
endmodule

bind lfsr_dual_form lfsr_dual_form_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_galois (sel_galois),
  .load       (load),
  .seed       (seed),
  .step_en    (step_en),
  .state_out  (state_out),
  .bit_out    (bit_out)
);

// File: tb/lfsr_dual_form_tb.sv
`timescale 1ns/1ps
module lfsr_dual_form_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_galois = 1'b0;
  logic        load = 1'b0;
  logic [15:0] seed = '0;
  logic        step_en = 1'b0;
  logic [15:0] state_out;
  logic        bit_out;

  int  n_vec = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  lfsr_dual_form u_dut (
    .clk        (clk),
    .rst        (rst),
    .sel_galois (sel_galois),
    .load       (load),
    .seed       (seed),
    .step_en    (step_en),
    .state_out  (state_out),
    .bit_out    (bit_out)
  );

  function automatic logic [15:0] ref_step(input logic gal, input logic [15:0] s);
    if (gal) ref_step = (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    else     ref_step = {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; load = 1'b0; step_en = 1'b0;
    tick(); tick();
    rst = 1'b0;
    chk("R1 state", state_out, 16'hACE1);
    chk("R1 bit", {15'b0, bit_out}, 16'h0000);
  endtask

  task automatic t_load(input logic [15:0] s);
    load = 1'b1; seed = s; step_en = 1'b0;
    tick();
    load = 1'b0;
    chk("R2 load", state_out, s);
  endtask

  task automatic t_load_held();
    logic b0;
    b0 = bit_out;
    load = 1'b1; seed = 16'h5A5A; step_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R3 held", state_out, 16'h5A5A);
      chk("R8 bit on load", {15'b0, bit_out}, {15'b0, b0});
    end
    load = 1'b0; step_en = 1'b0;
  endtask

  task automatic t_priority();
    sel_galois = 1'b0;
    t_load(16'h1234);
    load = 1'b1; seed = 16'h8001; step_en = 1'b1;
    tick();
    load = 1'b0; step_en = 1'b0;
    chk("R4 priority", state_out, 16'h8001);
  endtask

  task automatic t_idle();
    logic [15:0] s0;
    logic b0;
    sel_galois = 1'b1;
    t_load(16'h0F0F);
    step_en = 1'b1; tick(); step_en = 1'b0;
    s0 = state_out; b0 = bit_out;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R5 state", state_out, s0);
      chk("R5 bit", {15'b0, bit_out}, {15'b0, b0});
    end
  endtask

  task automatic t_steps(input logic gal, input logic [15:0] s, input string req);
    logic [15:0] exp;
    sel_galois = gal;
    t_load(s);
    exp = s;
    step_en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      logic lsb;
      lsb = exp[0];
      exp = ref_step(gal, exp);
      tick();
      chk(req, state_out, exp);
      chk("R8 serial", {15'b0, bit_out}, {15'b0, lsb});
    end
    step_en = 1'b0;
  endtask

  task automatic t_zero(input logic gal);
    sel_galois = gal;
    t_load(16'h0000);
    step_en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      chk("R9 zero lock", state_out, 16'h0000);
    end
    step_en = 1'b0;
  endtask

  task automatic t_period(input logic gal);
    int cnt;
    bit hit_zero;
    sel_galois = gal;
    t_load(16'h0001);
    cnt = 0; hit_zero = 1'b0;
    step_en = 1'b1;
    do begin
      tick();
      cnt++;
      if (state_out == 16'h0000) hit_zero = 1'b1;
    end while (state_out != 16'h0001 && cnt < 70000);
    step_en = 1'b0;
    chk("R10 period", cnt[15:0], 16'hFFFF);
    chk("R10 period high bits", cnt[31:16], 16'h0000);
    chk("R10 no zero", {15'b0, hit_zero}, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_load(16'hBEEF);
    t_load(16'h0000);
    t_load(16'h8000);
    t_load_held();
    t_priority();
    t_idle();
    t_steps(1'b0, 16'hACE1, "R6 fib step");
    t_steps(1'b0, 16'hFFFF, "R6 fib step");
    t_steps(1'b1, 16'hACE1, "R7 gal step");
    t_steps(1'b1, 16'h0001, "R7 gal step");
    t_zero(1'b0);
    t_zero(1'b1);
    t_period(1'b0);
    t_period(1'b1);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule